// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block runs one complete access to a 4096-word, 12-bit magnetic core array built from a 64 by 64 plane of selectable words. A requester presents an address, a read-or-write flag and write data. The block latches them and decodes the address into one X select line and one Y select line. It first pulses both lines in the clearing direction. Every addressed core that held a one returns a sense pulse, and those pulses are gathered into a memory buffer. It then pulses the same two lines in the setting direction, with a per-bit inhibit held against every bit that has to end up zero.

A read puts the gathered word back, so the destructive read leaves the array unchanged. A write stores the new data, and the word that was there before is still returned. Each phase lasts a configurable number of clocks. A one-cycle completion pulse marks the end of the access, and the read word stays on the output until the next request is accepted. The core plane, its drivers and its sense amplifiers are outside the block.

Top module: `core_mem_ctrl`

## Requirements
- R1: During a drive phase, `x_sel` has exactly bit `req_addr[5:0]` set and `y_sel` has exactly bit `req_addr[11:6]` set. At all other times both are zero.
- R2: For the PH clocks that follow acceptance, `drive_clear` is high with the select lines active and `drive_set` is low. `drive_clear` and `drive_set` are never high together.
- R3: The memory buffer takes the bitwise OR of every sense pulse seen during the clearing strobe phase and the latch phase that follows it. A read returns the stored word on `rd_data`.
- R4: After a read, a set phase follows with `inhibit` equal to the bitwise inverse of the word just read, so the array content is unchanged afterwards.
- R5: A write leaves `req_wdata` in the array, using `inhibit` = ~`req_wdata` during the set phase. Its `rd_data` is the word the location held before the write.
- R6: `inhibit` is non-zero only during the setup phase and the set phase, each PH clocks long. It is zero while `drive_clear` is high.
- R7: `busy` rises on the clock edge that accepts a request and stays high through `done`. `done` is a single-cycle pulse, 4·PH clock edges after acceptance. `busy` is low on the cycle after `done`.
- R8: A request presented while `busy` is high is ignored and changes no array location.
- R9: `rd_data` holds its value from `done` until the next request is accepted.
- R10: After reset, `busy`, `done`, `drive_clear`, `drive_set`, `x_sel`, `y_sel`, `inhibit` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 12 | Word address; bits 5:0 pick the X line, bits 11:6 the Y line |
| req_wdata | input | 12 | Data to store on a write |
| sense | input | 12 | Sense pulses from the array, one per bit |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 12 | Word read from the addressed location |
| x_sel | output | 64 | One-hot X select drive |
| y_sel | output | 64 | One-hot Y select drive |
| drive_clear | output | 1 | Select current in the direction that forces cores to zero |
| drive_set | output | 1 | Select current in the direction that sets cores to one |
| inhibit | output | 12 | Per-bit inhibit held against the set current |

## Verification
The hardest case to reach is a request that arrives in the middle of an access. It must neither corrupt the restore nor touch another location. The bench raises a write to a different address one clock into a read and drops it a clock later. It then confirms that the running access ends with the right timing and data, and that the stray location is still zero in the behavioural array. A second hard case is a write of zero over a word that holds ones, which can only be stored through the inhibit lines. The vector sequence writes a one, overwrites it with zero, and reads the word back.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int WORD_W    = 12;
    localparam int ADDR_W    = 12;
    localparam int GRP_W     = 3;
    localparam int LINE_BITS = ADDR_W / 2;
    localparam int LINES     = 1 << LINE_BITS;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STROBE,
        PH_LATCH,
        PH_SETUP,
        PH_SET,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } core_req_t;

    function automatic logic phase_drives(input phase_e ph);
        return (ph == PH_STROBE) || (ph == PH_SET);
    endfunction

    function automatic logic phase_inhibits(input phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_SET);
    endfunction

endpackage

// File: rtl/core_line_decode.sv
module core_line_decode
    import core_pkg::*;
(
    input  logic                 en,
    input  logic [LINE_BITS-1:0] code,
    output logic [LINES-1:0]     lines
);
    localparam int NGRP = LINE_BITS / GRP_W;
    localparam int GVAL = 1 << GRP_W;
    localparam int HALF = GVAL / 2;

    logic [GVAL-1:0] grp_hot [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP_W-1:0] s;
        assign s = code[g*GRP_W +: GRP_W];
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic half_en;
            assign half_en = en && (s[GRP_W-1] == h[0]);
            for (genvar v = 0; v < HALF; v++) begin : g_val
                assign grp_hot[g][h*HALF + v] = half_en && (s[GRP_W-2:0] == v[GRP_W-2:0]);
            end
        end
    end

    for (genvar hi = 0; hi < GVAL; hi++) begin : g_hi
        for (genvar lo = 0; lo < GVAL; lo++) begin : g_lo
            assign lines[hi*GVAL + lo] = grp_hot[1][hi] && grp_hot[0][lo];
        end
    end
endmodule

// File: rtl/core_phase_seq.sv
module core_phase_seq
    import core_pkg::*;
#(
    parameter int PH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   accept,
    output phase_e phase
);
    localparam int CW = (PH > 1) ? $clog2(PH) : 1;
    localparam logic [CW-1:0] LAST = CW'(PH - 1);

    logic [CW-1:0] cnt;
    logic          phase_end;

    assign accept    = (phase == PH_IDLE) && req_valid;
    assign phase_end = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (req_valid) phase <= PH_STROBE;
                end
                PH_STROBE, PH_LATCH, PH_SETUP, PH_SET: begin
                    if (phase_end) begin
                        cnt   <= '0;
                        phase <= phase_e'(phase + 3'd1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/core_word_path.sv
module core_word_path
    import core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  core_req_t         req_in,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] sense,
    output core_req_t         held,
    output logic [WORD_W-1:0] mbr,
    output logic [WORD_W-1:0] inhibit
);
    logic [WORD_W-1:0] restore_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            mbr  <= '0;
        end else if (accept) begin
            held <= req_in;
            mbr  <= '0;
        end else if (phase == PH_STROBE || phase == PH_LATCH) begin
            mbr <= mbr | sense;
        end
    end

    assign restore_word = held.wr ? held.wdata : mbr;
    assign inhibit      = phase_inhibits(phase) ? ~restore_word : '0;
endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl
    import core_pkg::*;
#(
    parameter int PH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [11:0] req_wdata,
    input  logic [11:0] sense,
    output logic        busy,
    output logic        done,
    output logic [11:0] rd_data,
    output logic [63:0] x_sel,
    output logic [63:0] y_sel,
    output logic        drive_clear,
    output logic        drive_set,
    output logic [11:0] inhibit
);
    phase_e    phase;
    logic      accept;
    core_req_t req_in;
    core_req_t held;
    logic      sel_en;

    assign req_in = '{wr: req_write, addr: req_addr, wdata: req_wdata};

    core_phase_seq #(.PH(PH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .accept    (accept),
        .phase     (phase)
    );

    core_word_path u_path (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req_in  (req_in),
        .phase   (phase),
        .sense   (sense),
        .held    (held),
        .mbr     (rd_data),
        .inhibit (inhibit)
    );

    assign sel_en = phase_drives(phase);

    core_line_decode u_xdec (
        .en    (sel_en),
        .code  (held.addr[LINE_BITS-1:0]),
        .lines (x_sel)
    );

    core_line_decode u_ydec (
        .en    (sel_en),
        .code  (held.addr[ADDR_W-1:LINE_BITS]),
        .lines (y_sel)
    );

    assign drive_clear = (phase == PH_STROBE);
    assign drive_set   = (phase == PH_SET);
    assign busy        = (phase != PH_IDLE);
    assign done        = (phase == PH_DONE);
endmodule

// File: rtl/core_mem_ctrl_chk.sv
module core_mem_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [11:0] rd_data,
    input logic [63:0] x_sel,
    input logic [63:0] y_sel,
    input logic        drive_clear,
    input logic        drive_set,
    input logic [11:0] inhibit
);
    // R1: a single X and a single Y line whenever either is active
    p_one_line_r1: assert property (@(posedge clk) disable iff (rst)
        (x_sel != '0 || y_sel != '0) |-> ($onehot(x_sel) && $onehot(y_sel)));

    // R1: selects only during a drive phase
    p_sel_in_drive_r1: assert property (@(posedge clk) disable iff (rst)
        (x_sel != '0) |-> (drive_clear || drive_set));

    // R2: the two current directions never overlap
    p_dir_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(drive_clear && drive_set));

    // R6: no inhibit while clearing
    p_no_inh_clear_r6: assert property (@(posedge clk) disable iff (rst)
        drive_clear |-> (inhibit == '0));

    // R7: busy holds until done, done lasts one cycle
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);

    // R9: read word holds while idle and nothing is accepted
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> $stable(rd_data));
endmodule

bind core_mem_ctrl core_mem_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .x_sel       (x_sel),
    .y_sel       (y_sel),
    .drive_clear (drive_clear),
    .drive_set   (drive_set),
    .inhibit     (inhibit)
);

// File: tb/tb_core_mem_ctrl.sv
module tb_core_mem_ctrl;
    localparam int P  = 3;
    localparam int NV = 13;

    // {write, address, write data, expected rd_data}
    localparam logic [36:0] VECS [NV] = '{
        {1'b1, 12'o1573, 12'o5252, 12'o0000},
        {1'b0, 12'o1573, 12'o0000, 12'o5252},
        {1'b0, 12'o1573, 12'o0000, 12'o5252},
        {1'b1, 12'o0000, 12'o7777, 12'o0000},
        {1'b0, 12'o0000, 12'o0000, 12'o7777},
        {1'b1, 12'o7777, 12'o0001, 12'o0000},
        {1'b1, 12'o7777, 12'o0000, 12'o0001},
        {1'b0, 12'o7777, 12'o0000, 12'o0000},
        {1'b1, 12'o1573, 12'o2525, 12'o5252},
        {1'b0, 12'o1573, 12'o0000, 12'o2525},
        {1'b0, 12'o0000, 12'o0000, 12'o7777},
        {1'b1, 12'o0100, 12'o4321, 12'o0000},
        {1'b0, 12'o0100, 12'o0000, 12'o4321}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [11:0] req_addr = '0;
    logic [11:0] req_wdata = '0;
    logic [11:0] sense;
    logic        busy, done, drive_clear, drive_set;
    logic [11:0] rd_data, inhibit;
    logic [63:0] x_sel, y_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    core_mem_ctrl #(.PH(P)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sense(sense),
        .busy(busy), .done(done), .rd_data(rd_data), .x_sel(x_sel), .y_sel(y_sel),
        .drive_clear(drive_clear), .drive_set(drive_set), .inhibit(inhibit)
    );

    // behavioural core plane: a word moves only with both selects driven
    logic [11:0] plane [int];

    function automatic int line_idx(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [11:0] peek(input logic [11:0] a);
        return plane.exists(int'(a)) ? plane[int'(a)] : 12'o0000;
    endfunction

    always @(posedge clk) begin
        int xi, yi, w;
        xi = line_idx(x_sel);
        yi = line_idx(y_sel);
        w  = yi * 64 + xi;
        sense <= '0;
        if (rst) sense <= '0;
        else if (xi >= 0 && yi >= 0) begin
            if (drive_clear) begin
                sense <= peek(12'(w));
                plane[w] = '0;
            end else if (drive_set) begin
                plane[w] = peek(12'(w)) | ~inhibit;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input logic [36:0] v, input bit poke_busy);
        logic        wr;
        logic [11:0] a, d, e, store;
        int k;
        {wr, a, d, e} = v;
        store = wr ? d : e;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0;
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        chk(drive_clear && !drive_set, "R2 clearing strobe", {drive_clear, drive_set}, 2'b10);
        chk(x_sel == (64'd1 << a[5:0]), "R1 x line", x_sel, 64'd1 << a[5:0]);
        chk(y_sel == (64'd1 << a[11:6]), "R1 y line", y_sel, 64'd1 << a[11:6]);
        chk(inhibit == '0, "R6 no inhibit in strobe", inhibit, 0);
        k = 0;
        while (1) begin
            @(posedge clk); #1;
            k++;
            if (poke_busy && k == 1) begin
                req_valid = 1; req_write = 1; req_addr = 12'o3333; req_wdata = 12'o7777;
            end
            if (poke_busy && k == 2) req_valid = 0;
            if (k == P) chk(x_sel == '0 && y_sel == '0, "R1 no select in latch", x_sel, 0);
            if (k == 2*P) begin
                chk(inhibit == ~store, "R6 inhibit in setup", inhibit, ~store);
                chk(x_sel == '0 && !drive_set, "R1 no select in setup", x_sel, 0);
            end
            if (k == 3*P) begin
                chk(drive_set && !drive_clear, "R5 set strobe", {drive_clear, drive_set}, 2'b01);
                chk(inhibit == ~store, wr ? "R5 inhibit is inverted data" : "R4 inhibit restores read word",
                    inhibit, ~store);
            end
            if (done || k > 20*P) break;
        end
        chk(k == 4*P, "R7 done latency", k, 4*P);
        chk(rd_data == e, wr ? "R5 old word on write" : "R3 read word", rd_data, e);
        @(posedge clk); #1;
        chk(!busy && !done, "R7 idle after done", {busy, done}, 0);
        chk(peek(a) == store, wr ? "R5 array holds written word" : "R4 array restored", peek(a), store);
        repeat (3) @(posedge clk);
        #1;
        chk(rd_data == e, "R9 rd_data held", rd_data, e);
        if (poke_busy)
            chk(peek(12'o3333) == 12'o0000, "R8 busy request ignored", peek(12'o3333), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !drive_clear && !drive_set, "R10 reset flags",
            {busy, done, drive_clear, drive_set}, 0);
        chk(x_sel == '0 && y_sel == '0, "R10 reset selects", x_sel | y_sel, 0);
        chk(inhibit == '0 && rd_data == '0, "R10 reset data", {inhibit, rd_data}, 0);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < NV; i++) run_access(VECS[i], i == 2);
        // a write of zero over ones needs the inhibit on every bit
        run_access({1'b1, 12'o0000, 12'o0000, 12'o7777}, 1'b0);
        run_access({1'b0, 12'o0000, 12'o0000, 12'o0000}, 1'b0);
        // unrelated locations untouched by all of the above
        chk(peek(12'o1572) == 12'o0000, "R1 neighbour word untouched", peek(12'o1572), 0);
        chk(peek(12'o0100) == 12'o4321, "R4 earlier word kept", peek(12'o0100), 12'o4321);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule